// File: doc/BRIEF.md
# SDRAM Boot and Refresh Sequencer

This block sits on the controller side of an SDRAM interface. When reset is released it drives the start-up command series: a precharge of every bank, two auto-refresh commands, and a load of the mode register. Each command is spaced from the one before it by a fixed number of clocks, set by parameters for precharge recovery, refresh cycle time and mode-load recovery. When the last spacing has elapsed, the block raises `ready` and hands the command bus to the rest of the controller.

During normal operation an interval timer keeps track of how far apart refreshes may be. The spacing is derived from 4096 refreshes in every 64 ms at the configured clock rate. When the timer expires, a refresh becomes pending. The rest of the controller asks for the bus with `userReq` and owns it while `userGrant` is high. A pending refresh is never forced onto an active user access. It waits until the user drops its request, then closes all banks and issues one auto-refresh. While the user holds the bus, the sequencer drives NOP on its own command pins. Outside reset, CKE stays high at all times.

Top module: `sdram_boot_refresh`

## Requirements
- R1: While reset is held, the command pins read deselect ({csN,rasN,casN,weN} = 1111), `cke`, `ready` and `userGrant` are 0.
- R2: `cke` is high from the first cycle after reset release and stays high.
- R3: Command codes on {csN,rasN,casN,weN} are PRE = 0010, REF = 0001, MRS = 0000 and NOP = 0111. After reset, the pins show PRE with address bit 10 high in the first cycle, then REF, REF, MRS, and no other non-NOP command before `ready`.
- R4: The first REF comes exactly T_RP cycles after the PRE. The second REF comes exactly T_RFC cycles after the first. The MRS comes exactly T_RFC cycles after the second REF.
- R5: During MRS the address is the MODE_WORD parameter with bits 11:10 forced to 0, and `ba` is 0.
- R6: `ready` rises exactly T_MRD cycles after the MRS cycle and stays high.
- R7: The refresh interval is CLK_MHZ*64000/4096 cycles. With no user activity, the cycles of consecutive REF commands are exactly one interval apart, and each REF comes exactly T_RP cycles after a PRE with address bit 10 high.
- R8: With `ready` high and no refresh pending, `userGrant` goes high the cycle after `userReq` rises and low the cycle after it falls. While `userGrant` is high, the pins show NOP.
- R9: A refresh that falls due while `userGrant` is high issues no command until `userReq` drops. Its PRE then appears exactly 2 cycles after `userGrant` falls.
- R10: A request raised while a refresh is under way is granted exactly T_RFC cycles after that refresh's REF, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| userReq | input | 1 | User side asks for the command bus |
| userGrant | output | 1 | User side owns the command bus |
| ready | output | 1 | Start-up series complete |
| cke | output | 1 | SDRAM clock enable |
| csN | output | 1 | Chip select, active low |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address, held 0 |
| addr | output | ADDR_W | Address bus (bit 10 selects all banks for PRE) |

## Verification
The embedded assertions check several properties on every cycle:
- CKE stays high once it has risen, and `ready` never falls.
- A grant is only given after `ready`, and the pins show NOP whenever the user owns the bus.
- Every precharge has address bit 10 high, and every mode load has bits 11:10 clear.
- The spacing counter never counts below zero, and a pending refresh clears once it is issued.

The exact command order and spacing, the rise of `ready` after the mode load, and the refresh spacing can only be shown by the bench. The same holds for deferring a refresh behind a long user grant and for the late grant of a request raised during a refresh. The bench shows these by logging every non-NOP command with its cycle number.

// File: rtl/sbr_pkg.sv
package sbr_pkg;

  // Command encodings on {csN, rasN, casN, weN}
  localparam logic [3:0] CMD_DESEL = 4'b1111;
  localparam logic [3:0] CMD_NOP   = 4'b0111;
  localparam logic [3:0] CMD_PRE   = 4'b0010;
  localparam logic [3:0] CMD_REF   = 4'b0001;
  localparam logic [3:0] CMD_MRS   = 4'b0000;

  typedef enum logic [2:0] {
    ST_PRE,
    ST_WAIT_RP,
    ST_REF,
    ST_WAIT_RFC,
    ST_MRS,
    ST_WAIT_MRD,
    ST_IDLE
  } seqState_t;

  typedef enum logic [1:0] {
    WAIT_RP  = 2'd0,
    WAIT_RFC = 2'd1,
    WAIT_MRD = 2'd2
  } waitSel_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic     issuePre;
    logic     issueRef;
    logic     issueMrs;
    logic     loadWait;
    waitSel_t waitSel;
    logic     countDown;
  } seqStrobe_t;

endpackage

// File: rtl/sbr_datapath.sv
module sbr_datapath
  import sbr_pkg::*;
#(
  parameter int              ADDR_W       = 12,
  parameter int              T_RP         = 3,
  parameter int              T_RFC        = 9,
  parameter int              T_MRD        = 2,
  parameter int              REF_INTERVAL = 781,
  parameter logic [ADDR_W-1:0] MODE_WORD  = 12'h032
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic              runTimer,
  output logic              waitZero,
  output logic              refPending,
  output logic              cke,
  output logic              csN,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic [1:0]        ba,
  output logic [ADDR_W-1:0] addr
);

  localparam int MAX_T  = (T_RFC > T_RP) ? ((T_RFC > T_MRD) ? T_RFC : T_MRD)
                                         : ((T_RP > T_MRD) ? T_RP : T_MRD);
  localparam int WAIT_W = $clog2(MAX_T + 1);
  localparam int IVL_W  = $clog2(REF_INTERVAL + 1);
  localparam logic [ADDR_W-1:0] LOW_MASK   = {{(ADDR_W-10){1'b0}}, {10{1'b1}}};
  localparam logic [ADDR_W-1:0] MODE_CLEAN = MODE_WORD & LOW_MASK;
  localparam logic [ADDR_W-1:0] ALL_BANKS  = ADDR_W'(1) << 10;

  // Spacing counter between commands
  logic [WAIT_W-1:0] waitCnt;
  logic [WAIT_W-1:0] loadVal;

  always_comb begin
    case (strobe.waitSel)
      WAIT_RP:  loadVal = WAIT_W'(T_RP - 2);
      WAIT_RFC: loadVal = WAIT_W'(T_RFC - 2);
      default:  loadVal = WAIT_W'(T_MRD - 2);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      waitCnt <= '0;
    end else if (strobe.loadWait) begin
      waitCnt <= loadVal;
    end else if (strobe.countDown) begin
      waitCnt <= waitCnt - 1'b1;
    end
  end

  assign waitZero = (waitCnt == '0);

  // Refresh interval timer
  logic [IVL_W-1:0] ivlCnt;
  logic             ivlHit;
  logic             pendQ;

  assign ivlHit = runTimer && (ivlCnt == IVL_W'(REF_INTERVAL - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ivlCnt <= '0;
      pendQ  <= 1'b0;
    end else begin
      if (runTimer) begin
        ivlCnt <= ivlHit ? '0 : ivlCnt + 1'b1;
      end
      if (ivlHit) begin
        pendQ <= 1'b1;
      end else if (strobe.issueRef) begin
        pendQ <= 1'b0;
      end
    end
  end

  assign refPending = pendQ;

  // Registered command pins
  logic [3:0]        cmdQ;
  logic [ADDR_W-1:0] addrQ;
  logic              ckeQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdQ  <= CMD_DESEL;
      addrQ <= '0;
      ckeQ  <= 1'b0;
    end else begin
      ckeQ <= 1'b1;
      if (strobe.issuePre) begin
        cmdQ  <= CMD_PRE;
        addrQ <= ALL_BANKS;
      end else if (strobe.issueRef) begin
        cmdQ  <= CMD_REF;
        addrQ <= '0;
      end else if (strobe.issueMrs) begin
        cmdQ  <= CMD_MRS;
        addrQ <= MODE_CLEAN;
      end else begin
        cmdQ  <= CMD_NOP;
        addrQ <= '0;
      end
    end
  end

  assign {csN, rasN, casN, weN} = cmdQ;
  assign addr = addrQ;
  assign ba   = 2'b00;
  assign cke  = ckeQ;

  AST_WAIT_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    strobe.countDown |-> (waitCnt != '0)); // R4

  AST_PENDING_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.issueRef && pendQ && !ivlHit) |=> !pendQ); // R7

endmodule

// File: rtl/sbr_ctrl.sv
module sbr_ctrl
  import sbr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       userReq,
  input  logic       waitZero,
  input  logic       refPending,
  output seqStrobe_t strobe,
  output logic       ready,
  output logic       grant
);

  seqState_t state, stateNext;
  logic initPhase;
  logic secondRef;
  logic readyQ;
  logic grantQ;

  always_comb begin
    strobe    = '0;
    stateNext = state;
    case (state)
      ST_PRE: begin
        strobe.issuePre = 1'b1;
        strobe.loadWait = 1'b1;
        strobe.waitSel  = WAIT_RP;
        stateNext       = ST_WAIT_RP;
      end
      ST_WAIT_RP: begin
        if (waitZero) stateNext = ST_REF;
        else          strobe.countDown = 1'b1;
      end
      ST_REF: begin
        strobe.issueRef = 1'b1;
        strobe.loadWait = 1'b1;
        strobe.waitSel  = WAIT_RFC;
        stateNext       = ST_WAIT_RFC;
      end
      ST_WAIT_RFC: begin
        if (waitZero) begin
          if (initPhase && !secondRef) stateNext = ST_REF;
          else if (initPhase)          stateNext = ST_MRS;
          else                         stateNext = ST_IDLE;
        end else begin
          strobe.countDown = 1'b1;
        end
      end
      ST_MRS: begin
        strobe.issueMrs = 1'b1;
        strobe.loadWait = 1'b1;
        strobe.waitSel  = WAIT_MRD;
        stateNext       = ST_WAIT_MRD;
      end
      ST_WAIT_MRD: begin
        if (waitZero) stateNext = ST_IDLE;
        else          strobe.countDown = 1'b1;
      end
      ST_IDLE: begin
        if (refPending && !grantQ) stateNext = ST_PRE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_PRE;
      initPhase <= 1'b1;
      secondRef <= 1'b0;
      readyQ    <= 1'b0;
      grantQ    <= 1'b0;
    end else begin
      state <= stateNext;
      if (state == ST_WAIT_RFC && waitZero && initPhase) secondRef <= 1'b1;
      if (state == ST_WAIT_MRD && waitZero) initPhase <= 1'b0;
      if (state == ST_IDLE) begin
        readyQ <= 1'b1;
        if (grantQ && !userReq) begin
          grantQ <= 1'b0;
        end else if (!grantQ && userReq && readyQ && !refPending) begin
          grantQ <= 1'b1;
        end
      end
    end
  end

  assign ready = readyQ;
  assign grant = grantQ;

  AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    readyQ |=> readyQ); // R6

  AST_GRANT_NEEDS_READY: assert property (@(posedge clk) disable iff (!rstN)
    grantQ |-> readyQ); // R8

  AST_NO_REFRESH_UNDER_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    grantQ |-> !(strobe.issuePre || strobe.issueRef || strobe.issueMrs)); // R9

endmodule

// File: rtl/sdram_boot_refresh.sv
module sdram_boot_refresh
  import sbr_pkg::*;
#(
  parameter int              ADDR_W            = 12,
  parameter int              CLK_MHZ           = 50,
  parameter int              REFRESH_COUNT     = 4096,
  parameter int              REFRESH_WINDOW_US = 64000,
  parameter int              T_RP              = 3,
  parameter int              T_RFC             = 9,
  parameter int              T_MRD             = 2,
  parameter logic [ADDR_W-1:0] MODE_WORD       = 12'h032
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              userReq,
  output logic              userGrant,
  output logic              ready,
  output logic              cke,
  output logic              csN,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic [1:0]        ba,
  output logic [ADDR_W-1:0] addr
);

  localparam int REF_INTERVAL = CLK_MHZ * REFRESH_WINDOW_US / REFRESH_COUNT;

  seqStrobe_t strobe;
  logic waitZero;
  logic refPending;

  sbr_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .userReq    (userReq),
    .waitZero   (waitZero),
    .refPending (refPending),
    .strobe     (strobe),
    .ready      (ready),
    .grant      (userGrant)
  );

  sbr_datapath #(
    .ADDR_W       (ADDR_W),
    .T_RP         (T_RP),
    .T_RFC        (T_RFC),
    .T_MRD        (T_MRD),
    .REF_INTERVAL (REF_INTERVAL),
    .MODE_WORD    (MODE_WORD)
  ) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .runTimer   (ready),
    .waitZero   (waitZero),
    .refPending (refPending),
    .cke        (cke),
    .csN        (csN),
    .rasN       (rasN),
    .casN       (casN),
    .weN        (weN),
    .ba         (ba),
    .addr       (addr)
  );

  AST_CKE_STAYS_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    cke |=> cke); // R2

  AST_NOP_WHILE_GRANTED: assert property (@(posedge clk) disable iff (!rstN)
    userGrant |-> ({csN, rasN, casN, weN} == CMD_NOP)); // R8

  AST_PRE_ALL_BANKS: assert property (@(posedge clk) disable iff (!rstN)
    ({csN, rasN, casN, weN} == CMD_PRE) |-> addr[10]); // R3

  AST_MRS_TOP_BITS_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    ({csN, rasN, casN, weN} == CMD_MRS) |-> (addr[11:10] == 2'b00 && ba == 2'b00)); // R5

endmodule

// File: tb/sdram_boot_refresh_bench.sv
`timescale 1ns/1ps
module sdram_boot_refresh_bench;

  localparam int T_RP  = 3;
  localparam int T_RFC = 9;
  localparam int T_MRD = 2;
  localparam int IVL   = 50 * 64000 / 4096;
  localparam logic [3:0] NOP = 4'b0111, PRE = 4'b0010, REF = 4'b0001, MRS = 4'b0000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic userReq = 1'b0;
  logic userGrant, ready, cke, csN, rasN, casN, weN;
  logic [1:0]  ba;
  logic [11:0] addr;

  always #10 clk = ~clk;

  sdram_boot_refresh #(.MODE_WORD(12'hC32)) u_sdram_boot_refresh (
    .clk(clk), .rstN(rstN), .userReq(userReq), .userGrant(userGrant),
    .ready(ready), .cke(cke), .csN(csN), .rasN(rasN), .casN(casN),
    .weN(weN), .ba(ba), .addr(addr)
  );

  int total = 0;
  int bad = 0;

  // Command log
  int         cyc = 0;
  int         evN = 0;
  int         evCyc [0:127];
  logic [3:0] evCmd [0:127];
  logic [11:0] evAddr [0:127];
  logic [1:0] evBa [0:127];
  int  ckeLow = 0;
  int  cmdUnderGrant = 0;
  int  readyRise = -1;
  int  grantFall = -1;
  int  grantRise = -1;
  logic readyPrev = 1'b0;
  logic grantPrev = 1'b0;

  always @(negedge clk) begin
    if (rstN) begin
      cyc = cyc + 1;
      if (!cke) ckeLow = ckeLow + 1;
      if ({csN, rasN, casN, weN} != NOP) begin
        if (userGrant) cmdUnderGrant = cmdUnderGrant + 1;
        if (evN < 128) begin
          evCyc[evN]  = cyc;
          evCmd[evN]  = {csN, rasN, casN, weN};
          evAddr[evN] = addr;
          evBa[evN]   = ba;
          evN = evN + 1;
        end
      end
      if (ready && !readyPrev) readyRise = cyc;
      if (!userGrant && grantPrev) grantFall = cyc;
      if (userGrant && !grantPrev) grantRise = cyc;
      readyPrev = ready;
      grantPrev = userGrant;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    total = total + 1;
    if (act != exp) begin
      bad = bad + 1;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic waitEvents(input int n, input int limit);
    for (int i = 0; i < limit && evN < n; i++) tick();
  endtask

  task automatic t_reset();
    rstN = 1'b0;
    repeat (4) tick();
    chk("R1", "pins in reset", int'({csN, rasN, casN, weN}), 15);
    chk("R1", "cke in reset", int'(cke), 0);
    chk("R1", "ready in reset", int'(ready), 0);
    chk("R1", "grant in reset", int'(userGrant), 0);
    rstN = 1'b1;
  endtask

  task automatic t_init();
    for (int i = 0; i < 200 && !ready; i++) tick();
    repeat (2) tick();
    chk("R3", "events before ready", evN, 4);
    chk("R3", "first cmd PRE", int'(evCmd[0]), int'(PRE));
    chk("R3", "PRE cycle", evCyc[0], 1);
    chk("R3", "PRE a10", int'(evAddr[0][10]), 1);
    chk("R3", "second cmd REF", int'(evCmd[1]), int'(REF));
    chk("R3", "third cmd REF", int'(evCmd[2]), int'(REF));
    chk("R3", "fourth cmd MRS", int'(evCmd[3]), int'(MRS));
    chk("R4", "PRE to REF", evCyc[1] - evCyc[0], T_RP);
    chk("R4", "REF to REF", evCyc[2] - evCyc[1], T_RFC);
    chk("R4", "REF to MRS", evCyc[3] - evCyc[2], T_RFC);
    chk("R5", "mode word", int'(evAddr[3]), 12'h032);
    chk("R5", "mode bank", int'(evBa[3]), 0);
    chk("R6", "ready delay", readyRise - evCyc[3], T_MRD);
    chk("R2", "cke low cycles", ckeLow, 0);
  endtask

  task automatic t_periodic();
    waitEvents(10, 3 * IVL + 100);
    chk("R7", "op PRE", int'(evCmd[4]), int'(PRE));
    chk("R7", "op PRE a10", int'(evAddr[4][10]), 1);
    chk("R7", "op REF", int'(evCmd[5]), int'(REF));
    chk("R7", "PRE to REF", evCyc[5] - evCyc[4], T_RP);
    chk("R7", "interval 1", evCyc[7] - evCyc[5], IVL);
    chk("R7", "interval 2", evCyc[9] - evCyc[7], IVL);
    chk("R6", "ready held", int'(ready), 1);
  endtask

  task automatic t_grant();
    repeat (T_RFC + 5) tick();
    userReq = 1'b1;
    tick();
    chk("R8", "grant after req", int'(userGrant), 1);
    repeat (5) tick();
    chk("R8", "grant held", int'(userGrant), 1);
    userReq = 1'b0;
    tick();
    chk("R8", "grant after drop", int'(userGrant), 0);
    chk("R8", "commands under grant", cmdUnderGrant, 0);
  endtask

  task automatic t_block();
    int nBefore;
    int preCyc;
    userReq = 1'b1;
    tick();
    nBefore = evN;
    repeat (IVL + 200) tick();
    chk("R9", "no cmd while granted", evN, nBefore);
    chk("R9", "grant kept", int'(userGrant), 1);
    userReq = 1'b0;
    waitEvents(nBefore + 1, 50);
    preCyc = evCyc[nBefore];
    userReq = 1'b1;
    chk("R9", "deferred PRE", int'(evCmd[nBefore]), int'(PRE));
    chk("R9", "PRE after grant fall", preCyc - grantFall, 2);
    waitEvents(nBefore + 2, 50);
    chk("R9", "deferred REF", int'(evCmd[nBefore + 1]), int'(REF));
    for (int i = 0; i < 50 && !userGrant; i++) tick();
    chk("R10", "late grant", grantRise - evCyc[nBefore + 1], T_RFC);
    userReq = 1'b0;
    repeat (2) tick();
    chk("R8", "commands under grant", cmdUnderGrant, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad = bad + 1;
    total = total + 1;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_init();
    t_periodic();
    t_grant();
    t_block();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule